// File: doc/BRIEF.md
# Configuration Source Selector with OTP Programming and Lockout

This block holds the configuration of a power converter. It keeps three volatile configuration bytes and three one-time-programmable (OTP) shadow bytes. The OTP bytes are modelled as a sticky register array: a bit set to 1 stays at 1. A command register picks, for each byte on its own, whether the active value comes from the volatile byte or from the OTP byte. A bus slave drives the block through a single-cycle register write port and a combinational read port.

The command register clears on power-up, on shutdown, on an under-voltage lockout and on a thermal lockout. Because the select bits live in that register, clearing it makes the OTP bytes the active configuration after every restart. The volatile bytes are never cleared.

The block also runs an OTP program command. When the programming supply is present, the command ORs the volatile bytes into the OTP bytes. A lock bit in the active configuration freezes all configuration changes, but the soft-reset and switch-off command bits keep working. The active power-up sequence field decides whether the outputs may be enabled.

Top module: `cfgsel_core`

## Requirements
- R1: The command register holds the select bits in bits [2:0], one bit per byte index. With select bit i at 1, active byte i (`active_cfg[8i+7:8i]`) equals volatile byte i. With select bit i at 0, it equals OTP byte i.
- R2: One cycle after `shutdown` is high, all select bits are 0 and `active_cfg` equals the OTP contents.
- R3: The command register is read at address 4. It reads 00h after reset, and it reads 00h in the cycle after `shutdown`, `uvlo_fault` or `thermal_fault` is high.
- R4: Volatile bytes 0..2 are written and read at addresses 0..2. They keep their value through shutdown and both fault lockouts.
- R5: Writing command bit 7 (program request) while `prog_supply_ok` is high sets that bit for exactly one cycle. At the end of that cycle, each OTP byte becomes its old value ORed with the matching volatile byte, and bit 7 reads 0 again.
- R6: Programming never clears an OTP bit. A second program leaves old|new in each byte.
- R7: A program request written while `prog_supply_ok` is low is ignored: bit 7 reads 0 and the OTP bytes are unchanged.
- R8: The lock is bit 7 of active byte 2. While it is 1, the following are refused: writes to volatile bytes, changes to select bits, and program requests.
- R9: While locked, command bit 6 (soft reset, driving `soft_rst`) and bit 5 (switch off, driving `sw_off`) still accept writes.
- R10: After reset all OTP bytes read as 00h. `outputs_en` is high only when bits [1:0] of active byte 2 (power-up sequence field) are non-zero.
- R11: Reads of the undefined addresses 3, 5, 6 and 7 return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| wr_en | input | 1 | Register write strobe from bus slave |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| shutdown | input | 1 | Shutdown request, clears command register |
| uvlo_fault | input | 1 | Under-voltage lockout, clears command register |
| thermal_fault | input | 1 | Thermal lockout, clears command register |
| prog_supply_ok | input | 1 | OTP programming supply present |
| active_cfg | output | 24 | Active configuration bytes, byte i at [8i+7:8i] |
| outputs_en | output | 1 | Power-up sequence field non-zero |
| soft_rst | output | 1 | Soft-reset command bit |
| sw_off | output | 1 | Switch-off command bit |

## Verification
The bench builds the block with its defaults: three bytes of eight bits and the command register at address 4. This small configuration lets the bench sweep all eight select patterns and every address of the 3-bit space. It also runs each of the three clearing inputs in turn. With only three bytes, a chain of two programs can be followed by hand to show the OR accumulation. The same chain reaches both lock paths: the lock bit taken from a volatile byte, and the lock bit burned into OTP and so still in force after a shutdown.

// File: rtl/cfgsel_pkg.sv
// Package: shared bit positions of the configuration selector.
// Assumes 8-bit data bytes; command and field positions are fixed.
package cfgsel_pkg;
    localparam int CMD_PROG_BIT  = 7;   // program request, self-clearing
    localparam int CMD_SRST_BIT  = 6;   // soft reset command
    localparam int CMD_SWOFF_BIT = 5;   // switch-off command
    localparam int LOCK_BIT      = 7;   // lock bit inside lock byte
    localparam int SEQ_LSB       = 0;   // power-up sequence field
    localparam int SEQ_W         = 2;
endpackage

// File: rtl/cfgsel_vreg.sv
// Volatile configuration bytes. Never reset: contents survive shutdown
// and faults. Writes are refused while the lock is active.
module cfgsel_vreg #(
    parameter int NBYTES = 3,
    parameter int DW     = 8,
    parameter int AW     = 3
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    input  logic                       locked,
    output logic [NBYTES-1:0][DW-1:0]  reg_q
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Load byte i on an unlocked write to its address.
        always_ff @(posedge clk) begin
            if (wr_en && !locked && (addr == AW'(i)))
                reg_q[i] <= wdata;
        end
    end
endmodule

// File: rtl/cfgsel_otp.sv
// OTP shadow bytes as a sticky array: programming ORs the volatile bytes
// in, so a bit at 1 never returns to 0. Reset models a blank part.
module cfgsel_otp #(
    parameter int NBYTES = 3,
    parameter int DW     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prog,
    input  logic [NBYTES-1:0][DW-1:0]  reg_q,
    output logic [NBYTES-1:0][DW-1:0]  otp_q
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Blank on reset, accumulate volatile data on a program cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                otp_q[i] <= '0;
            else if (prog)
                otp_q[i] <= otp_q[i] | reg_q[i];
        end
    end
endmodule

// File: rtl/cfgsel_cmd.sv
// Command register: select bits, soft-reset, switch-off and a program
// request that lasts one cycle. Cleared by reset, shutdown and faults.
// While locked only the soft-reset and switch-off bits take writes.
module cfgsel_cmd
    import cfgsel_pkg::*;
#(
    parameter int NBYTES = 3,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_cmd,
    input  logic [DW-1:0] wdata,
    input  logic          locked,
    input  logic          prog_supply_ok,
    output logic [DW-1:0] cmd_q
);
    localparam logic [DW-1:0] SEL_MASK  = DW'((1 << NBYTES) - 1);
    localparam logic [DW-1:0] KEEP_MASK = SEL_MASK
                                        | (DW'(1) << CMD_SRST_BIT)
                                        | (DW'(1) << CMD_SWOFF_BIT);
    localparam logic [DW-1:0] LOCK_MASK = (DW'(1) << CMD_SRST_BIT)
                                        | (DW'(1) << CMD_SWOFF_BIT);

    logic [DW-1:0] next_unlocked;

    // Build the unlocked write value; program bit only with supply present.
    always_comb begin
        next_unlocked = wdata & KEEP_MASK;
        next_unlocked[CMD_PROG_BIT] = wdata[CMD_PROG_BIT] & prog_supply_ok;
    end

    // Register update with clear priority, lock gating and program self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cmd_q <= '0;
        else if (wr_cmd && locked)
            cmd_q <= (cmd_q & ~LOCK_MASK) | (wdata & LOCK_MASK);
        else if (wr_cmd)
            cmd_q <= next_unlocked;
        else
            cmd_q[CMD_PROG_BIT] <= 1'b0;
    end
endmodule

// File: rtl/cfgsel_mux.sv
// Per-byte source selection: select bit 1 takes the volatile byte,
// 0 takes the OTP byte.
module cfgsel_mux #(
    parameter int NBYTES = 3,
    parameter int DW     = 8
) (
    input  logic [NBYTES-1:0]          sel,
    input  logic [NBYTES-1:0][DW-1:0]  reg_q,
    input  logic [NBYTES-1:0][DW-1:0]  otp_q,
    output logic [NBYTES-1:0][DW-1:0]  act
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign act[i] = sel[i] ? reg_q[i] : otp_q[i];
    end
endmodule

// File: rtl/cfgsel_core.sv
// Top of the configuration selector. Connects volatile bytes, OTP array,
// command register and source mux; decodes reads. The lock comes from
// the active (selected) copy of the last byte.
module cfgsel_core
    import cfgsel_pkg::*;
#(
    parameter int NBYTES   = 3,
    parameter int DW       = 8,
    parameter int AW       = 3,
    parameter int CMD_ADDR = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 shutdown,
    input  logic                 uvlo_fault,
    input  logic                 thermal_fault,
    input  logic                 prog_supply_ok,
    output logic [NBYTES*DW-1:0] active_cfg,
    output logic                 outputs_en,
    output logic                 soft_rst,
    output logic                 sw_off
);
    localparam int LOCK_BYTE = NBYTES - 1;

    logic [NBYTES-1:0][DW-1:0] reg_q, otp_q, act;
    logic [DW-1:0]             cmd_q;
    logic                      locked;
    logic                      wr_cmd;
    logic                      clear;
    logic [NBYTES*DW-1:0]      reg_flat, otp_flat;

    assign clear    = shutdown | uvlo_fault | thermal_fault;
    assign wr_cmd   = wr_en && (addr == AW'(CMD_ADDR));
    assign locked   = act[LOCK_BYTE][LOCK_BIT];
    assign reg_flat = reg_q;
    assign otp_flat = otp_q;

    cfgsel_vreg #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_vreg (
        .clk(clk), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .locked(locked), .reg_q(reg_q)
    );

    cfgsel_otp #(.NBYTES(NBYTES), .DW(DW)) u_otp (
        .clk(clk), .rst_n(rst_n), .prog(cmd_q[CMD_PROG_BIT]),
        .reg_q(reg_q), .otp_q(otp_q)
    );

    cfgsel_cmd #(.NBYTES(NBYTES), .DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .clear(clear), .wr_cmd(wr_cmd),
        .wdata(wdata), .locked(locked), .prog_supply_ok(prog_supply_ok),
        .cmd_q(cmd_q)
    );

    cfgsel_mux #(.NBYTES(NBYTES), .DW(DW)) u_mux (
        .sel(cmd_q[NBYTES-1:0]), .reg_q(reg_q), .otp_q(otp_q), .act(act)
    );

    assign active_cfg = act;
    assign outputs_en = |act[LOCK_BYTE][SEQ_LSB +: SEQ_W];
    assign soft_rst   = cmd_q[CMD_SRST_BIT];
    assign sw_off     = cmd_q[CMD_SWOFF_BIT];

    // Read decode: volatile bytes, command register, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == AW'(CMD_ADDR))
            rdata = cmd_q;
        for (int i = 0; i < NBYTES; i++)
            if (addr == AW'(i))
                rdata = reg_q[i];
    end
endmodule

// File: rtl/cfgsel_checker.sv
// Checker for cfgsel_core: temporal properties on clearing, OTP
// stickiness, program pulse and lock behaviour. Bound to the top below.
module cfgsel_checker
    import cfgsel_pkg::*;
#(
    parameter int NBYTES   = 3,
    parameter int DW       = 8,
    parameter int AW       = 3,
    parameter int CMD_ADDR = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic                 shutdown,
    input logic                 uvlo_fault,
    input logic                 thermal_fault,
    input logic                 prog_supply_ok,
    input logic                 locked,
    input logic [DW-1:0]        cmd_q,
    input logic [NBYTES*DW-1:0] reg_flat,
    input logic [NBYTES*DW-1:0] otp_flat,
    input logic [NBYTES*DW-1:0] active_cfg
);
    assert_cmd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown || uvlo_fault || thermal_fault) |=> (cmd_q == '0));

    assert_otp_after_shdn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (active_cfg == otp_flat));

    assert_otp_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((otp_flat & $past(otp_flat)) == $past(otp_flat)));

    assert_prog_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[CMD_PROG_BIT] && !(wr_en && addr == AW'(CMD_ADDR)))
        |=> !cmd_q[CMD_PROG_BIT]);

    assert_prog_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_q[CMD_PROG_BIT]) |-> $past(prog_supply_ok));

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && (int'(addr) < NBYTES)) |=> $stable(reg_flat));
endmodule

bind cfgsel_core cfgsel_checker #(
    .NBYTES(NBYTES), .DW(DW), .AW(AW), .CMD_ADDR(CMD_ADDR)
) i_cfgsel_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .shutdown(shutdown), .uvlo_fault(uvlo_fault),
    .thermal_fault(thermal_fault), .prog_supply_ok(prog_supply_ok),
    .locked(locked), .cmd_q(cmd_q), .reg_flat(reg_flat),
    .otp_flat(otp_flat), .active_cfg(active_cfg)
);

// File: tb/test_cfgsel_core.sv
`timescale 1ns/1ps
module test_cfgsel_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        shutdown = 1'b0, uvlo_fault = 1'b0, thermal_fault = 1'b0;
    logic        prog_supply_ok = 1'b0;
    logic [23:0] active_cfg;
    logic        outputs_en, soft_rst, sw_off;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] m_reg [3];
    logic [7:0] m_otp [3];

    always #4 clk = ~clk;

    cfgsel_core i_cfgsel_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .shutdown(shutdown), .uvlo_fault(uvlo_fault),
        .thermal_fault(thermal_fault), .prog_supply_ok(prog_supply_ok),
        .active_cfg(active_cfg), .outputs_en(outputs_en),
        .soft_rst(soft_rst), .sw_off(sw_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [23:0] exp_act(input logic [2:0] s);
        logic [23:0] e;
        for (int i = 0; i < 3; i++)
            e[i*8 +: 8] = s[i] ? m_reg[i] : m_otp[i];
        return e;
    endfunction

    task automatic chk_act(input string req, input logic [2:0] s);
        logic [23:0] e;
        e = exp_act(s);
        chk(req, {8'h0, active_cfg}, {8'h0, e});
        chk(req, {31'h0, outputs_en}, {31'h0, |e[17:16]});
    endtask

    task automatic prog_model();
        for (int i = 0; i < 3; i++) m_otp[i] = m_otp[i] | m_reg[i];
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 3; i++) m_otp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R3 R10 R11: reset state, blank OTP, undefined addresses
        rd(3'd4, d); chk("R3 cmd after reset", {24'h0, d}, 32'h0);
        chk_act("R10 blank OTP", 3'b000);
        chk("R10 outputs_en blank", {31'h0, outputs_en}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            if (a == 3 || a > 4) begin
                rd(3'(a), d); chk("R11 undefined addr", {24'h0, d}, 32'h0);
            end
        end

        // R4: volatile write and readback
        m_reg[0] = 8'hA5; m_reg[1] = 8'h3C; m_reg[2] = 8'h0F;
        for (int i = 0; i < 3; i++) wr(3'(i), m_reg[i]);
        for (int i = 0; i < 3; i++) begin
            rd(3'(i), d); chk("R4 readback", {24'h0, d}, {24'h0, m_reg[i]});
        end

        // R1 R10: sweep all select patterns
        for (int s = 0; s < 8; s++) begin
            wr(3'd4, 8'(s));
            rd(3'd4, d); chk("R1 cmd sel", {24'h0, d}, s);
            chk_act("R1 R10 sweep", 3'(s));
        end

        // R2 R3 R4: each clearing input in turn
        for (int k = 0; k < 3; k++) begin
            wr(3'd4, 8'h07);
            @(negedge clk);
            shutdown = (k == 0); uvlo_fault = (k == 1); thermal_fault = (k == 2);
            @(negedge clk);
            shutdown = 1'b0; uvlo_fault = 1'b0; thermal_fault = 1'b0;
            #1;
            rd(3'd4, d); chk("R3 cmd cleared", {24'h0, d}, 32'h0);
            chk_act("R2 OTP active after clear", 3'b000);
            for (int i = 0; i < 3; i++) begin
                rd(3'(i), d); chk("R4 retained", {24'h0, d}, {24'h0, m_reg[i]});
            end
        end

        // R7: program without supply is ignored
        prog_supply_ok = 1'b0;
        wr(3'd4, 8'h80);
        rd(3'd4, d); chk("R7 prog bit refused", {24'h0, d}, 32'h0);
        tick();
        chk_act("R7 OTP unchanged", 3'b000);

        // R5: program with supply
        m_reg[0] = 8'h21; m_reg[1] = 8'h42; m_reg[2] = 8'h03;
        for (int i = 0; i < 3; i++) wr(3'(i), m_reg[i]);
        prog_supply_ok = 1'b1;
        wr(3'd4, 8'h80);
        rd(3'd4, d); chk("R5 prog bit set", {24'h0, d}, 32'h80);
        tick();
        prog_model();
        rd(3'd4, d); chk("R5 prog bit self-clear", {24'h0, d}, 32'h0);
        chk_act("R5 OTP programmed", 3'b000);

        // R6: second program accumulates
        m_reg[0] = 8'h10; m_reg[1] = 8'h04; m_reg[2] = 8'h00;
        for (int i = 0; i < 3; i++) wr(3'(i), m_reg[i]);
        wr(3'd4, 8'h80);
        tick();
        prog_model();
        chk_act("R6 OTP sticky OR", 3'b000);
        chk("R6 byte0 value", {8'h0, active_cfg}, 32'h00_03_46_31);

        // R8: lock from volatile byte 2
        m_reg[2] = 8'h83; wr(3'd2, 8'h83);
        wr(3'd4, 8'h04);
        chk_act("R8 locked config active", 3'b100);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); chk("R8 reg write refused", {24'h0, d}, {24'h0, m_reg[0]});
        wr(3'd2, 8'h00);
        rd(3'd2, d); chk("R8 lock byte write refused", {24'h0, d}, 32'h83);
        wr(3'd4, 8'h87);
        rd(3'd4, d); chk("R8 sel and prog refused", {24'h0, d}, 32'h04);
        tick();
        chk_act("R8 OTP unchanged under lock", 3'b100);

        // R9: soft reset and switch off still act
        wr(3'd4, 8'h60);
        rd(3'd4, d); chk("R9 cmd under lock", {24'h0, d}, 32'h64);
        chk("R9 soft_rst", {31'h0, soft_rst}, 32'h1);
        chk("R9 sw_off", {31'h0, sw_off}, 32'h1);

        // R2: shutdown restores OTP source and unlocks
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk); shutdown = 1'b0; #1;
        chk_act("R2 OTP after shutdown", 3'b000);
        chk("R9 sw_off cleared", {31'h0, sw_off}, 32'h0);
        m_reg[0] = 8'h55; wr(3'd0, 8'h55);
        rd(3'd0, d); chk("R8 unlocked write", {24'h0, d}, 32'h55);

        // R8: lock burned into OTP persists
        wr(3'd4, 8'h80);
        tick();
        prog_model();
        chk_act("R6 OTP with lock bit", 3'b000);
        wr(3'd0, 8'hAA);
        rd(3'd0, d); chk("R8 OTP lock refuses write", {24'h0, d}, 32'h55);
        wr(3'd4, 8'h07);
        rd(3'd4, d); chk("R8 OTP lock refuses sel", {24'h0, d}, 32'h0);
        wr(3'd4, 8'h20);
        rd(3'd4, d); chk("R9 sw_off under OTP lock", {24'h0, d}, 32'h20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule